// File: doc/BRIEF.md
# Windowed Frame Sync Protector

This block sits behind a bit-clock recovery loop and turns a serial channel-bit stream into framed symbol words. Each incoming bit arrives with a one-cycle enable. The block first converts the level-coded stream to NRZ form: a 1 means the level changed since the previous bit. It then keeps the last 24 NRZ bits and compares them against a fixed frame marker made of two 11-bit runs. At the nominal speed the enables arrive at about 4.32 MHz.

The block is protected against defects. Once locked, it trusts a marker only when the marker ends within a small tolerance of the predicted frame boundary, which lies 588 enables after the previous boundary. If no trusted marker shows up by the far edge of that tolerance, the block produces a substitute strobe and carries on as if the boundary had fallen exactly on the prediction. If too many substitutes occur in a row, the block drops lock and accepts the next marker wherever it appears.

Between boundaries, the block skips the 3 merging bits that follow every field, gathers 14 channel bits, and presents them as one parallel symbol word. There are 33 symbol words per frame. The 14-to-8 lookup that comes after this block is not part of it.

Top module: `frame_sync_protector`

## Requirements
- R1: While reset is asserted and after it, frame_stb, frame_interp, sym_valid and locked are 0 and sym_word is all zeros; no symbol word is emitted before the first frame boundary.
- R2: Each enabled input bit is turned into one NRZ bit, which is 1 when bit_in differs from the previous enabled bit_in; the level before the first bit is taken as 0.
- R3: The marker is the NRZ sequence 1000_0000_0001_0000_0000_0010, with the leftmost bit received first. Bit positions count enables since the last strobe, and the strobe's own bit is position 0. While locked, a marker whose last bit lands at a position from FRAME_BITS-WIN_HALF to FRAME_BITS+WIN_HALF is accepted. The cycle after that enable shows frame_stb=1 with frame_interp=0, and counting restarts at 0.
- R4: While locked, if position FRAME_BITS+WIN_HALF is reached with no accepted marker, the cycle after that enable shows frame_stb=1 with frame_interp=1, and counting resumes at position WIN_HALF, as if the boundary had come on time. A marker on that same bit wins over the substitute strobe.
- R5: While locked, a marker that ends outside the window produces no strobe and leaves the position count unchanged.
- R6: An accepted marker sets locked to 1. LOSS_LIMIT consecutive substitute strobes clear it, and locked falls in the same cycle as the substitute strobe that reaches the limit.
- R7: While unlocked, a marker ending at any position is accepted as in R3. Substitute strobes keep being produced every FRAME_BITS+WIN_HALF positions.
- R8: After each strobe, the block skips 3 merging bits. The next 14 NRZ bits form sym_word, first-received bit in bit 13, and sym_valid pulses for one cycle after the enable of the last of those bits. The pattern then repeats with 3 skipped and 14 taken bits, for SYMS_PER_FRAME words per frame. After a substitute strobe, the slots are measured from the predicted boundary.
- R9: A cycle without bit_en changes no state and produces no frame_stb or sym_valid in the next cycle.
- R10: frame_stb and sym_valid are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies bit_in for one cycle per recovered channel bit |
| bit_in | input | 1 | Level-coded channel bit |
| frame_stb | output | 1 | Frame boundary pulse |
| frame_interp | output | 1 | With frame_stb: 1 for a substitute strobe, 0 for a detected marker |
| locked | output | 1 | Frame timing is locked |
| sym_word | output | 14 | Parallel symbol word, first bit in the MSB |
| sym_valid | output | 1 | sym_word is new this cycle |

## Verification
The bench builds the block with its default frame shape (33 symbols of 14 bits, 3 merging bits, a window of ±2) but lowers the loss limit to 3. The lower limit means a single shifted stream can walk the block through a run of substitute strobes, loss of lock and reacquisition in a few frames. The stimulus shifts markers to the window edges at -2 and +2 and to +5, outside the window. It also removes a marker, mixes sparse and back-to-back enables, and adds long idle stretches. This exercises the accept-versus-substitute priority at the far window edge.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    // Length of the frame marker in channel bits
    localparam int SYNC_BITS = 24;

    // Frame marker in NRZ form, first-received bit in the MSB
    localparam logic [SYNC_BITS-1:0] SYNC_WORD = 24'b1000_0000_0001_0000_0000_0010;

    // What happened at a frame boundary on the current enable
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_FOUND  = 2'd1,
        EV_FILLED = 2'd2
    } frame_ev_e;

endpackage

// File: rtl/fsp_nrz_shift.sv
module fsp_nrz_shift
    import fsp_pkg::*;
#(
    parameter int TAIL_BITS = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 bit_in,
    output logic [TAIL_BITS-1:0] tail_d,
    output logic                 match
);

    typedef struct packed {
        logic                 level;
        logic [SYNC_BITS-1:0] hist;
    } nrz_state_t;

    nrz_state_t state_q, state_d;
    logic       nrz_bit;

    always_comb begin
        state_d = state_q;
        nrz_bit = bit_in ^ state_q.level;
        if (bit_en) begin
            state_d.level = bit_in;
            state_d.hist  = {state_q.hist[SYNC_BITS-2:0], nrz_bit};
        end
        // The newest bits, including the one arriving now
        tail_d = state_d.hist[TAIL_BITS-1:0];
        match  = bit_en && (state_d.hist == SYNC_WORD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/fsp_frame_timer.sv
module fsp_frame_timer
    import fsp_pkg::*;
#(
    parameter int FRAME_BITS = 588,
    parameter int WIN_HALF   = 2,
    parameter int LOSS_LIMIT = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      match,
    output frame_ev_e ev,
    output logic      frame_stb,
    output logic      frame_interp,
    output logic      locked
);

    localparam int POS_W  = $clog2(FRAME_BITS + WIN_HALF + 1);
    localparam int MISS_W = $clog2(LOSS_LIMIT + 1);

    localparam logic [POS_W-1:0]  WIN_LO   = POS_W'(FRAME_BITS - WIN_HALF);
    localparam logic [POS_W-1:0]  WIN_HI   = POS_W'(FRAME_BITS + WIN_HALF);
    localparam logic [POS_W-1:0]  POS_FILL = POS_W'(WIN_HALF);
    localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(LOSS_LIMIT);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [MISS_W-1:0] miss;
        logic              stb;
        logic              interp;
        logic              locked;
    } timer_state_t;

    timer_state_t     state_q, state_d;
    logic [POS_W-1:0] pos_inc;
    logic             in_window;
    logic             hunting;

    always_comb begin
        state_d        = state_q;
        state_d.stb    = 1'b0;
        state_d.interp = 1'b0;
        ev             = EV_NONE;
        pos_inc        = state_q.pos + 1'b1;
        in_window      = (pos_inc >= WIN_LO) && (pos_inc <= WIN_HI);
        hunting        = (state_q.miss == MISS_MAX);

        if (bit_en) begin
            if (match && (hunting || in_window)) begin
                ev             = EV_FOUND;
                state_d.pos    = '0;
                state_d.miss   = '0;
                state_d.stb    = 1'b1;
            end else if (pos_inc == WIN_HI) begin
                ev             = EV_FILLED;
                state_d.pos    = POS_FILL;
                state_d.miss   = hunting ? state_q.miss : state_q.miss + 1'b1;
                state_d.stb    = 1'b1;
                state_d.interp = 1'b1;
            end else begin
                state_d.pos    = pos_inc;
            end
        end
        state_d.locked = (state_d.miss != MISS_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.miss   <= MISS_MAX;
        end else begin
            state_q        <= state_d;
        end
    end

    assign frame_stb    = state_q.stb;
    assign frame_interp = state_q.interp;
    assign locked       = state_q.locked;

    // R5: the position never runs past the far edge of the window
    a_r5_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.pos <= WIN_HI);

    // R6: lock is only ever lost on a substitute strobe
    a_r6_drop_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.locked) |-> (state_q.stb && state_q.interp));

    // R6: a detected marker always leaves the block locked
    a_r6_found_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.stb && !state_q.interp) |-> state_q.locked);

    // R9: no enable, no strobe on the next cycle
    a_r9_idle_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !state_q.stb);

endmodule

// File: rtl/fsp_symbol_slicer.sv
module fsp_symbol_slicer
    import fsp_pkg::*;
#(
    parameter int SYM_BITS       = 14,
    parameter int MERGE_BITS     = 3,
    parameter int SYMS_PER_FRAME = 33,
    parameter int WIN_HALF       = 2   // must stay below SYM_BITS+MERGE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  frame_ev_e           ev,
    input  logic [SYM_BITS-1:0] word_in,
    output logic [SYM_BITS-1:0] sym_word,
    output logic                sym_valid
);

    localparam int SLOT  = SYM_BITS + MERGE_BITS;
    localparam int PH_W  = $clog2(SLOT + 1);
    localparam int IDX_W = $clog2(SYMS_PER_FRAME + 1);

    localparam logic [PH_W-1:0]  SLOT_END = PH_W'(SLOT);
    localparam logic [PH_W-1:0]  PH_FILL  = PH_W'(WIN_HALF);
    localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(SYMS_PER_FRAME);

    typedef struct packed {
        logic [PH_W-1:0]     phase;
        logic [IDX_W-1:0]    idx;
        logic [SYM_BITS-1:0] word;
        logic                valid;
    } slicer_state_t;

    slicer_state_t   state_q, state_d;
    logic [PH_W-1:0] ph_inc;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        ph_inc        = state_q.phase + 1'b1;

        unique case (ev)
            EV_FOUND: begin
                state_d.phase = '0;
                state_d.idx   = '0;
            end
            EV_FILLED: begin
                state_d.phase = PH_FILL;
                state_d.idx   = '0;
            end
            default: begin
                if (bit_en && (state_q.idx != IDX_MAX)) begin
                    if (ph_inc == SLOT_END) begin
                        state_d.phase = '0;
                        state_d.idx   = state_q.idx + 1'b1;
                        state_d.word  = word_in;
                        state_d.valid = 1'b1;
                    end else begin
                        state_d.phase = ph_inc;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.idx <= IDX_MAX;
        end else begin
            state_q     <= state_d;
        end
    end

    assign sym_word  = state_q.word;
    assign sym_valid = state_q.valid;

    // R8: never more symbols than a frame holds
    a_r8_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.idx <= IDX_MAX);

    // R9: no enable, no symbol on the next cycle
    a_r9_idle_no_sym: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !state_q.valid);

endmodule

// File: rtl/frame_sync_protector.sv
module frame_sync_protector
    import fsp_pkg::*;
#(
    parameter int SYM_BITS       = 14,
    parameter int MERGE_BITS     = 3,
    parameter int SYMS_PER_FRAME = 33,
    parameter int WIN_HALF       = 2,
    parameter int LOSS_LIMIT     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic                frame_stb,
    output logic                frame_interp,
    output logic                locked,
    output logic [SYM_BITS-1:0] sym_word,
    output logic                sym_valid
);

    localparam int FRAME_BITS = SYNC_BITS + MERGE_BITS
                              + SYMS_PER_FRAME * (SYM_BITS + MERGE_BITS);

    logic [SYM_BITS-1:0] tail_d;
    logic                match;
    frame_ev_e           ev;

    fsp_nrz_shift #(
        .TAIL_BITS (SYM_BITS)
    ) u_nrz (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .tail_d (tail_d),
        .match  (match)
    );

    fsp_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .WIN_HALF   (WIN_HALF),
        .LOSS_LIMIT (LOSS_LIMIT)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .match        (match),
        .ev           (ev),
        .frame_stb    (frame_stb),
        .frame_interp (frame_interp),
        .locked       (locked)
    );

    fsp_symbol_slicer #(
        .SYM_BITS       (SYM_BITS),
        .MERGE_BITS     (MERGE_BITS),
        .SYMS_PER_FRAME (SYMS_PER_FRAME),
        .WIN_HALF       (WIN_HALF)
    ) u_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .ev        (ev),
        .word_in   (tail_d),
        .sym_word  (sym_word),
        .sym_valid (sym_valid)
    );

    // R10: boundary and symbol pulses never coincide
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_stb && sym_valid));

    // R10: a strobe lasts exactly one cycle
    a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

endmodule

// File: tb/frame_sync_protector_test.sv
module frame_sync_protector_test;
    import fsp_pkg::*;

    localparam int W  = 2;
    localparam int L  = 3;
    localparam int S  = 33;
    localparam int SB = 14;
    localparam int MB = 3;
    localparam int F  = 24 + MB + S * (SB + MB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          bit_in = 1'b0;
    logic          frame_stb, frame_interp, locked, sym_valid;
    logic [SB-1:0] sym_word;

    always #4 clk = ~clk;

    frame_sync_protector #(
        .SYM_BITS (SB), .MERGE_BITS (MB), .SYMS_PER_FRAME (S),
        .WIN_HALF (W), .LOSS_LIMIT (L)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .bit_in (bit_in),
        .frame_stb (frame_stb), .frame_interp (frame_interp), .locked (locked),
        .sym_word (sym_word), .sym_valid (sym_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    int            m_pos, m_miss, m_phase, m_idx;
    logic          m_level;
    logic [23:0]   m_hist;
    logic          exp_stb, exp_interp, exp_locked, exp_valid;
    logic [SB-1:0] exp_word;

    // observed activity
    int c_det = 0, c_int = 0, c_sym = 0;
    bit saw_unlock = 1'b0;
    bit stream[$];
    logic drive_level = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_miss = L; m_phase = 0; m_idx = S;
        m_level = 1'b0; m_hist = '0;
        exp_stb = 0; exp_interp = 0; exp_locked = 0; exp_valid = 0; exp_word = '0;
    endtask

    task automatic model_step(bit en, bit b);
        exp_stb = 0; exp_interp = 0; exp_valid = 0;
        if (en) begin
            int  pn;
            bit  nrz, lk, inw;
            nrz     = b ^ m_level;
            m_level = b;
            m_hist  = {m_hist[22:0], nrz};
            pn      = m_pos + 1;
            lk      = (m_miss < L);
            inw     = (pn >= F - W) && (pn <= F + W);
            if (m_hist == SYNC_WORD && (!lk || inw)) begin
                m_pos = 0; m_miss = 0; m_phase = 0; m_idx = 0;
                exp_stb = 1;
            end else if (pn == F + W) begin
                m_pos = W; m_phase = W; m_idx = 0;
                if (m_miss < L) m_miss++;
                exp_stb = 1; exp_interp = 1;
            end else begin
                m_pos = pn;
                if (m_idx < S) begin
                    m_phase++;
                    if (m_phase == SB + MB) begin
                        exp_valid = 1;
                        exp_word  = m_hist[SB-1:0];
                        m_phase   = 0;
                        m_idx++;
                    end
                end
            end
        end
        exp_locked = (m_miss < L);
    endtask

    task automatic compare();
        check(frame_stb == exp_stb, "R3", "frame_stb", int'(frame_stb), int'(exp_stb));
        if (exp_stb)
            check(frame_interp == exp_interp, "R4", "frame_interp", int'(frame_interp), int'(exp_interp));
        check(locked == exp_locked, "R6", "locked", int'(locked), int'(exp_locked));
        check(sym_valid == exp_valid, "R8", "sym_valid", int'(sym_valid), int'(exp_valid));
        if (exp_valid)
            check(sym_word == exp_word, "R8 R2", "sym_word", int'(sym_word), int'(exp_word));
        check(!(frame_stb && sym_valid), "R10", "stb_and_valid", int'(frame_stb && sym_valid), 0);
        if (frame_stb) begin
            if (frame_interp) c_int++;
            else c_det++;
        end
        if (sym_valid) c_sym++;
        if (!locked) saw_unlock = 1'b1;
    endtask

    // call at a falling edge; returns at the next falling edge
    task automatic cycle(bit en, bit b);
        bit_en = en;
        bit_in = b;
        @(posedge clk);
        model_step(en, b);
        @(negedge clk);
        compare();
    endtask

    task automatic run_stream(bit dense);
        while (stream.size() > 0) begin
            bit en;
            en = dense ? 1'b1 : ($urandom_range(0, 2) != 0);
            if (en) begin
                drive_level ^= stream.pop_front();
                cycle(1'b1, drive_level);
            end else begin
                cycle(1'b0, ~drive_level);
            end
        end
    endtask

    function automatic void push_zeros(int n);
        for (int i = 0; i < n; i++) stream.push_back(1'b0);
    endfunction

    function automatic void push_frame(bit with_sync, int trim);
        for (int i = 23; i >= 0; i--) stream.push_back(with_sync ? SYNC_WORD[i] : 1'b0);
        push_zeros(MB);
        for (int s = 0; s < S; s++) begin
            int v;
            v = $urandom_range(0, (1 << SB) - 1);
            for (int i = SB - 1; i >= 0; i--) stream.push_back(v[i]);
            push_zeros(MB);
        end
        for (int i = 0; i < trim; i++) void'(stream.pop_back());
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int d0, i0, s0;
        void'($urandom(7));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset values
        check(frame_stb == 0 && frame_interp == 0, "R1", "strobe in reset", int'(frame_stb), 0);
        check(locked == 0, "R1", "locked in reset", int'(locked), 0);
        check(sym_valid == 0 && sym_word == '0, "R1", "symbol in reset", int'(sym_word), 0);
        rst_n = 1'b1;
        repeat (4) cycle(1'b0, 1'b0);
        check(locked == 0, "R1", "locked after reset", int'(locked), 0);

        // R7 R3 R8: acquisition from unlocked, clean frames, sparse enables
        d0 = c_det; i0 = c_int; s0 = c_sym;
        push_zeros(30);
        for (int k = 0; k < 6; k++) push_frame(1'b1, 0);
        run_stream(1'b0);
        check(c_det - d0 == 6, "R7", "detected strobes", c_det - d0, 6);
        check(c_int - i0 == 0, "R3", "substitute strobes", c_int - i0, 0);
        check(c_sym - s0 == 6 * S, "R8", "symbol count", c_sym - s0, 6 * S);
        check(locked == 1, "R6", "locked after acquisition", int'(locked), 1);

        // R4: one missing marker is filled in
        d0 = c_det; i0 = c_int;
        push_frame(1'b0, 0);
        push_frame(1'b1, 0);
        push_frame(1'b1, 0);
        run_stream(1'b0);
        check(c_int - i0 == 1, "R4", "substitute strobes", c_int - i0, 1);
        check(c_det - d0 == 2, "R4", "detected strobes", c_det - d0, 2);
        check(locked == 1, "R6", "lock kept", int'(locked), 1);

        // R3: markers at +1, -2 and +2 (far edge wins over fill)
        d0 = c_det; i0 = c_int;
        push_zeros(1);
        push_frame(1'b1, 0);
        push_frame(1'b1, 2);
        push_frame(1'b1, 0);
        push_zeros(2);
        push_frame(1'b1, 0);
        push_frame(1'b1, 0);
        run_stream(1'b0);
        check(c_det - d0 == 5, "R3", "in-window detections", c_det - d0, 5);
        check(c_int - i0 == 0, "R3", "no fill at edges", c_int - i0, 0);

        // R5 R6 R7: markers at +5 ignored, lock lost, reacquired
        d0 = c_det; i0 = c_int; saw_unlock = 1'b0;
        push_zeros(5);
        for (int k = 0; k < 6; k++) push_frame(1'b1, 0);
        run_stream(1'b0);
        check(c_int - i0 == L, "R5", "fills while markers off-window", c_int - i0, L);
        check(c_det - d0 == 4, "R7", "detections incl. reacquire", c_det - d0, 4);
        check(saw_unlock == 1, "R6", "lock dropped", int'(saw_unlock), 1);
        check(locked == 1, "R7", "lock regained", int'(locked), 1);

        // R9: idle enables change nothing
        d0 = c_det; i0 = c_int; s0 = c_sym;
        for (int k = 0; k < 60; k++) cycle(1'b0, k[0]);
        check(c_det + c_int + c_sym == d0 + i0 + s0, "R9", "events while idle",
              c_det + c_int + c_sym - d0 - i0 - s0, 0);
        check(locked == 1, "R9", "lock held while idle", int'(locked), 1);

        // R8 R10: back-to-back enables
        d0 = c_det; s0 = c_sym;
        for (int k = 0; k < 3; k++) push_frame(1'b1, 0);
        run_stream(1'b1);
        check(c_det - d0 == 3, "R3", "dense detections", c_det - d0, 3);
        check(c_sym - s0 == 3 * S, "R8", "dense symbol count", c_sym - s0, 3 * S);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule